// File: doc/BRIEF.md
# Serial Reply Frame Transmitter

This block sits in an I/O module next to the serial command receiver. When the receiver finishes a frame it raises a one-cycle strobe with the decoded command byte, the received FUNCTION and ID words, and the module's six parallel status words. For the three commands that require an answer, the block sends a reply frame of nine 16-bit words. The frame holds the FUNCTION echo, the ID echo, the six status words and a CRC over the status words. It sends the frame one bit per clock on a single serial line, most significant bit first.

All nine words pass through one 16-bit holding register. The first word is loaded directly from the strobe inputs. Each later word is loaded on the clock edge that shifts out the last bit of the word before it. The ID and status words come from a snapshot taken at the trigger. The CRC is accumulated bit by bit as the status bits leave the register, and the finished value is loaded as the ninth word. The block reports `busy` for the whole frame and pulses `done` once it ends.

Top module: `resp_frame_tx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ser_out` is 1, `busy` is 0 and `done` is 0.
- R2: A frame starts only when `rx_done` is high, the block is idle and `rx_cmd` is one of 8'h11 (identity check), 8'h12 (bulk set) or 8'h13 (pair output). Any other code leaves `busy` low and `ser_out` high.
- R3: The frame sends these words in order: `rx_func`, `rx_id`, then status words 0 to 5, where status word k is `stat_words[16k+15:16k]`. Each word is sent MSB first at one bit per clock. The first bit appears on `ser_out` in the cycle after the triggering clock edge.
- R4: The ninth word is a CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no bit reflection and no final XOR. It is computed over the 96 status bits in the order they are sent.
- R5: Changes to `rx_id`, `rx_func` or `stat_words` after the trigger edge do not alter the frame being sent.
- R6: A strobe that arrives while `busy` is high is ignored. It starts no frame and changes nothing in the current one.
- R7: `busy` stays high for exactly 144 consecutive cycles per frame. `done` is high for exactly one cycle, which is the first cycle after the last bit, and `busy` is low in that cycle.
- R8: `ser_out` is 1 in every cycle in which `busy` is low.
- R9: A strobe presented in the cycle where `done` is high is accepted, and a new frame follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle strobe from the receiver marking a decoded frame |
| rx_cmd | input | 8 | Decoded command byte, valid with `rx_done` |
| rx_func | input | 16 | Received FUNCTION word, echoed as reply word 0 |
| rx_id | input | 16 | Received ID word, echoed as reply word 1 |
| stat_words | input | 96 | Six parallel status words, word k at bits 16k+15:16k |
| ser_out | output | 1 | Serial reply line, idles high |
| busy | output | 1 | High while a reply frame is being shifted |
| done | output | 1 | One-cycle pulse after the last bit of a frame |

## Verification
The in-RTL properties assume that `rx_done` and `rx_cmd` are synchronous to `clk`. They also assume that `stat_words` and `rx_id` only need to be valid in the strobe cycle, and that reset is held for at least one edge before any strobe. The stimulus drives every input on the falling edge and holds `rx_done` for a single cycle. After each strobe it scrambles the data inputs, so any late sampling of the inputs would show up in the frame. It also sends strobes in three other situations: in the middle of a frame, with non-reply codes while idle, and in the `done` cycle. These are exactly the situations the properties on snapshot stability, busy length and idle level must hold through.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;

    localparam int DEF_WORD_W   = 16;
    localparam int DEF_NUM_STAT = 6;
    localparam int CMD_W        = 8;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam logic [CMD_W-1:0] CMD_IDCHK   = 8'h11;
    localparam logic [CMD_W-1:0] CMD_BULKSET = 8'h12;
    localparam logic [CMD_W-1:0] CMD_PAIROUT = 8'h13;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    function automatic logic wants_reply(input logic [CMD_W-1:0] cmd);
        return (cmd == CMD_IDCHK) || (cmd == CMD_BULKSET) || (cmd == CMD_PAIROUT);
    endfunction

endpackage

// File: rtl/resp_tx_seq.sv
module resp_tx_seq
    import resp_tx_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int FRAME_WORDS = DEF_NUM_STAT + 3,
    localparam int BIT_W      = $clog2(WORD_W),
    localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [CMD_W-1:0] cmd,
    output logic             start,
    output logic             load_next,
    output logic             shift_en,
    output logic             crc_en,
    output logic             frame_end,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             busy,
    output logic             done
);

    tx_state_e        state_q;
    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] word_q;
    logic             done_q;
    logic             end_word;
    logic             last_word;

    always_comb begin
        start     = trig && (state_q == ST_IDLE) && wants_reply(cmd);
        end_word  = (state_q == ST_SEND) && (bit_q == BIT_W'(WORD_W - 1));
        last_word = (word_q == IDX_W'(FRAME_WORDS - 1));
        load_next = end_word && !last_word;
        frame_end = end_word && last_word;
        shift_en  = (state_q == ST_SEND) && !load_next;
        crc_en    = (state_q == ST_SEND) && (word_q >= IDX_W'(2))
                    && (word_q <= IDX_W'(FRAME_WORDS - 2));
        nxt_idx   = word_q + IDX_W'(1);
        busy      = (state_q == ST_SEND);
        done      = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (start) begin
                state_q <= ST_SEND;
                bit_q   <= '0;
                word_q  <= '0;
            end else if (state_q == ST_SEND) begin
                bit_q <= end_word ? '0 : bit_q + BIT_W'(1);
                if (frame_end) begin
                    state_q <= ST_IDLE;
                end else if (end_word) begin
                    word_q <= word_q + IDX_W'(1);
                end
            end
        end
    end

    // R2
    no_reply_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && (state_q == ST_IDLE) && !wants_reply(cmd)) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/resp_tx_wordsel.sv
module resp_tx_wordsel
    import resp_tx_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int NUM_STAT = DEF_NUM_STAT,
    localparam int IDX_W   = $clog2(NUM_STAT + 3)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             capture,
    input  logic                             busy,
    input  logic                             frame_end,
    input  logic [WORD_W-1:0]                id_in,
    input  logic [NUM_STAT-1:0][WORD_W-1:0]  stat_in,
    input  logic [IDX_W-1:0]                 sel,
    input  logic [WORD_W-1:0]                crc_word,
    output logic [WORD_W-1:0]                word_o
);

    logic [WORD_W-1:0]               id_q;
    logic [NUM_STAT-1:0][WORD_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q   <= '0;
            stat_q <= '0;
        end else if (capture) begin
            id_q   <= id_in;
            stat_q <= stat_in;
        end
    end

    always_comb begin
        word_o = '1;
        if (sel == IDX_W'(1)) word_o = id_q;
        for (int k = 0; k < NUM_STAT; k++) begin
            if (sel == IDX_W'(k + 2)) word_o = stat_q[k];
        end
        if (sel == IDX_W'(NUM_STAT + 2)) word_o = crc_word;
    end

    // R5 R6
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_end) |=> ($stable(stat_q) && $stable(id_q)));

endmodule

// File: rtl/resp_tx_crc.sv
module resp_tx_crc
    import resp_tx_pkg::*;
#(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = CRC_POLY,
    parameter logic [15:0] SEED  = CRC_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_nxt
);

    logic [CRC_W-1:0] crc_q;
    logic             fb;

    always_comb begin
        fb      = crc_q[CRC_W-1] ^ bit_in;
        crc_nxt = crc_q;
        if (en) begin
            crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= SEED[CRC_W-1:0];
        else            crc_q <= crc_nxt;
    end

endmodule

// File: rtl/resp_tx_shifter.sv
module resp_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb
);

    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '1;
        else if (load)  hold_q <= load_word;
        else if (shift) hold_q <= {hold_q[WORD_W-2:0], 1'b1};
    end

    assign msb = hold_q[WORD_W-1];

endmodule

// File: rtl/resp_frame_tx.sv
module resp_frame_tx
    import resp_tx_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int NUM_STAT = DEF_NUM_STAT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_done,
    input  logic [CMD_W-1:0]           rx_cmd,
    input  logic [WORD_W-1:0]          rx_func,
    input  logic [WORD_W-1:0]          rx_id,
    input  logic [NUM_STAT*WORD_W-1:0] stat_words,
    output logic                       ser_out,
    output logic                       busy,
    output logic                       done
);

    localparam int FRAME_WORDS = NUM_STAT + 3;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int FRAME_BITS  = FRAME_WORDS * WORD_W;
    localparam int RUN_W       = $clog2(FRAME_BITS + 1);

    logic                            start, load_next, shift_en, crc_en, frame_end;
    logic [IDX_W-1:0]                nxt_idx;
    logic [WORD_W-1:0]               sel_word, load_word, crc_nxt;
    logic [NUM_STAT-1:0][WORD_W-1:0] stat_arr;

    assign stat_arr  = stat_words;
    assign load_word = start ? rx_func : sel_word;

    resp_tx_seq #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) u_seq (
        .clk(clk), .rst(rst), .trig(rx_done), .cmd(rx_cmd),
        .start(start), .load_next(load_next), .shift_en(shift_en),
        .crc_en(crc_en), .frame_end(frame_end), .nxt_idx(nxt_idx),
        .busy(busy), .done(done)
    );

    resp_tx_wordsel #(.WORD_W(WORD_W), .NUM_STAT(NUM_STAT)) u_sel (
        .clk(clk), .rst(rst), .capture(start), .busy(busy), .frame_end(frame_end),
        .id_in(rx_id), .stat_in(stat_arr), .sel(nxt_idx), .crc_word(crc_nxt),
        .word_o(sel_word)
    );

    resp_tx_crc #(.CRC_W(WORD_W)) u_crc (
        .clk(clk), .rst(rst), .clr(start), .en(crc_en), .bit_in(ser_out),
        .crc_nxt(crc_nxt)
    );

    resp_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(start || load_next), .load_word(load_word),
        .shift(shift_en), .msb(ser_out)
    );

    logic [RUN_W-1:0] busy_run;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else              busy_run <= busy_run + RUN_W'(1);
    end

    // R8
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ser_out);

    // R7
    end_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    frame_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == RUN_W'(FRAME_BITS)));

endmodule

// File: tb/test_resp_frame_tx.sv
`timescale 1ns/1ps
module test_resp_frame_tx;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_done = 1'b0;
    logic [7:0]  rx_cmd = '0;
    logic [15:0] rx_func = '0;
    logic [15:0] rx_id = '0;
    logic [95:0] stat_words = '0;
    logic        ser_out, busy, done;

    always #(CLK_NS / 2.0) clk = ~clk;

    resp_frame_tx i_resp_frame_tx (
        .clk(clk), .rst(rst), .rx_done(rx_done), .rx_cmd(rx_cmd),
        .rx_func(rx_func), .rx_id(rx_id), .stat_words(stat_words),
        .ser_out(ser_out), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int frames_exp = 0;
    int frames_seen = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [95:0] st);
        logic [15:0] c = 16'hFFFF;
        for (int w = 0; w < 6; w++) begin
            for (int b = 15; b >= 0; b--) begin
                if (c[15] ^ st[16*w + b]) c = {c[14:0], 1'b0} ^ 16'h1021;
                else                      c = {c[14:0], 1'b0};
            end
        end
        return c;
    endfunction

    task automatic push_frame(input logic [15:0] f, input logic [15:0] id, input logic [95:0] st);
        exp_q.push_back(f);  tag_q.push_back("R3 func echo");
        exp_q.push_back(id); tag_q.push_back("R3 id echo");
        for (int k = 0; k < 6; k++) begin
            exp_q.push_back(st[16*k +: 16]); tag_q.push_back("R3 status word");
        end
        exp_q.push_back(ref_crc(st)); tag_q.push_back("R4 crc word");
        frames_exp++;
    endtask

    task automatic send(input logic [7:0] cmd, input logic [15:0] f, input logic [15:0] id,
                        input logic [95:0] st, input bit expect_reply);
        @(negedge clk);
        rx_cmd = cmd; rx_func = f; rx_id = id; stat_words = st; rx_done = 1'b1;
        if (expect_reply) push_frame(f, id, st);
        @(negedge clk);
        rx_done = 1'b0;
        rx_func = ~f; rx_id = ~id; stat_words = ~st;   // R5 scramble after trigger
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || done || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    logic [15:0] acc = '0;
    int          nbits = 0;
    int          busy_len = 0;
    bit          done_prev = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) begin
                acc = {acc[14:0], ser_out};
                nbits++;
                busy_len++;
                if (nbits == 16) begin
                    nbits = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2/R6 unexpected word", {16'h0, acc}, 32'h0);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(acc == e, t, {16'h0, acc}, {16'h0, e});
                    end
                end
            end else begin
                check(ser_out == 1'b1, "R8 idle level", {31'h0, ser_out}, 32'h1);
            end
            if (done) begin
                check(busy_len == 144, "R7 busy length", busy_len, 144);
                check(nbits == 0, "R7 done on word boundary", nbits, 0);
                busy_len = 0;
                frames_seen++;
            end
            if (done && done_prev) check(1'b0, "R7 done width", 2, 1);
            done_prev = done;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(ser_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 in reset",
              {29'h0, ser_out, busy, done}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(ser_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 after reset",
              {29'h0, ser_out, busy, done}, 32'h4);
        mon_on = 1'b1;

        // R3 R4: each reply command with distinct data
        send(8'h11, 16'h1144, 16'h44F1, 96'h0123_4567_89AB_CDEF_0F1E_2D3C, 1'b1);
        wait_idle();
        send(8'h12, 16'h1234, 16'h8001, 96'h0000_0000_0000_0000_0000_0000, 1'b1);
        wait_idle();
        send(8'h13, 16'hFFFF, 16'h0000, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1);
        wait_idle();
        send(8'h13, 16'hA5A5, 16'h5A5A, 96'h8000_0001_7FFE_C3C3_0101_DEAD, 1'b1);
        wait_idle();

        // R2: non-reply codes start nothing
        send(8'h00, 16'h0011, 16'h2222, 96'h1, 1'b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 code 00 no frame", {31'h0, busy}, 0);
        send(8'h14, 16'h1400, 16'h3333, 96'h2, 1'b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 code 14 no frame", {31'h0, busy}, 0);
        send(8'h10, 16'h1000, 16'h4444, 96'h3, 1'b0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 code 10 no frame", {31'h0, busy}, 0);

        // R5 R6: inputs change and a strobe arrives mid-frame
        send(8'h11, 16'hBEEF, 16'hCAFE, 96'h1111_2222_3333_4444_5555_6666, 1'b1);
        repeat (30) @(negedge clk);
        stat_words = 96'h9999_8888_7777_AAAA_BBBB_CCCC;
        rx_id = 16'h7777;
        send(8'h12, 16'h0BAD, 16'hF00D, 96'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 1'b0);
        wait_idle();
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R6 ignored strobe gave no frame", {31'h0, busy}, 0);

        // R9: strobe in the done cycle
        send(8'h12, 16'h1357, 16'h2468, 96'h0F0F_F0F0_00FF_FF00_3C3C_C3C3, 1'b1);
        @(negedge clk);
        while (!done) @(negedge clk);
        rx_cmd = 8'h11; rx_func = 16'h9ABC; rx_id = 16'hDEF0;
        stat_words = 96'h0001_0002_0004_0008_0010_0020;
        rx_done = 1'b1;
        push_frame(16'h9ABC, 16'hDEF0, 96'h0001_0002_0004_0008_0010_0020);
        @(negedge clk);
        rx_done = 1'b0;
        check(busy == 1'b1, "R9 back-to-back accepted", {31'h0, busy}, 1);
        wait_idle();

        check(frames_seen == frames_exp, "R2/R6 frame count", frames_seen, frames_exp);
        check(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule